// File: doc/BRIEF.md
# External Bus Port Controller

This block sits between a small processor core and its external memory bus. It holds one 16-bit control word that software reaches as an ordinary data-space location at address 0xFFDE. That word sets how many extra cycles the port waits on external program fetches and on external data or peripheral accesses. It also carries a power-saving switch that stops the core's program address from reaching the external address pins. When that switch is on, program fetches are expected to come from on-chip memory only. External data traffic keeps working.

A three-state machine runs each external cycle. In IDLE it accepts one request; a data request wins over a program request in the same cycle. Transition IDLE->XFER puts the address on the pins and raises the strobe. In XFER, a wait count of zero takes transition XFER->IDLE. Any other count takes XFER->WAIT. WAIT holds the stall output high and counts down, and it takes WAIT->IDLE after the programmed number of stall cycles. WAIT->WAIT covers the remaining stall cycles.

A program request made while the switch is on starts no cycle. The pins keep their previous value, so nothing toggles, and the fetched result is undefined. After software turns the switch back off, the program path stays shut for one further cycle. This covers the pipeline delay. The hold and grant pull-down bits are only stored; no arbitration logic uses them.

Top module: `ext_bus_port`

## Requirements
- R1: After reset the control word reads 0x0021: hold (bit 15) = 0, grant pull-down (bit 13) = 0, program-path disable (bit 12) = 0, data wait field (bits 9:5) = 1 and program wait field (bits 4:0) = 1. Strobe and stall are low.
- R2: A data write (d_req=1, d_we=1) to address 0xFFDE loads bits 15, 13, 12, 9:5 and 4:0 from d_wdata, and the new value reads back on reg_rdata from the next cycle.
- R3: Bit 14 of reg_rdata is a read-only busy flag that is 1 exactly while ext_strobe is high. Bits 11:10 always read 0. Writes to bits 14 and 11:10 have no effect.
- R4: A request accepted in IDLE drives its address and ext_strobe=1 from the next cycle. Stall is then high for exactly N cycles, and the strobe lasts 1+N cycles. N is the program wait field for a program access and the data wait field for a data access, taken from the register value in the request cycle. N=0 gives a single strobe cycle with no stall.
- R5: When data and program requests arrive in the same IDLE cycle, the data access is served and ext_prog=0. Requests made while an access is in progress are dropped.
- R6: A data access to 0xFFDE is a register access and starts no external cycle.
- R7: While bit 12 is 1, a program request starts no cycle: ext_strobe stays low and ext_addr keeps its last value. Data accesses still run normally.
- R8: In the first cycle in which bit 12 reads 0 again after a clearing write, a program request is still blocked. From the following cycle, program requests run normally.
- R9: ext_addr changes only in the cycle where a new access begins, and it is stable for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_req | input | 1 | Data/peripheral access request |
| d_we | input | 1 | Data access is a write |
| d_addr | input | AW | Data access address |
| d_wdata | input | 16 | Write data (used for register writes) |
| p_req | input | 1 | Program fetch request |
| p_addr | input | AW | Program fetch address |
| reg_rdata | output | 16 | Control word readback including busy flag |
| ext_addr | output | AW | External address pins |
| ext_strobe | output | 1 | External access in progress |
| ext_prog | output | 1 | Current external access is a program fetch |
| stall | output | 1 | Wait cycle in progress; core must hold |

## Verification
A request driven in cycle c appears on the pins and strobe in cycle c+1. Stall follows in cycles c+2 through c+1+N, and the port is IDLE again in cycle c+2+N. A register write in cycle c shows on reg_rdata in cycle c+1. The bench drives inputs on the falling edge and samples on the following falling edges, walking through exactly these cycle offsets. Its expected wait counts come from a shadow copy of the control word, updated only when the bench's own writes complete. The bench tracks in which cycle a clearing write takes effect, so that it knows whether a program fetch is blocked or driven.

// File: rtl/ebp_pkg.sv
package ebp_pkg;
    localparam int WSW = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_WAIT
    } port_state_e;

    typedef struct packed {
        logic           hold;
        logic           gpd;
        logic           pdis;
        logic [WSW-1:0] dws;
        logic [WSW-1:0] pws;
    } bus_ctl_t;
endpackage

// File: rtl/ebp_ctrl_reg.sv
module ebp_ctrl_reg
    import ebp_pkg::*;
#(
    parameter int          AW       = 16,
    parameter logic [AW-1:0] REG_ADDR = 16'hFFDE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_req,
    input  logic          d_we,
    input  logic [AW-1:0] d_addr,
    input  logic [15:0]   d_wdata,
    input  logic          busy,
    output bus_ctl_t      ctl,
    output logic          is_reg,
    output logic [15:0]   rdata
);
    assign is_reg = d_req && (d_addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl.hold <= 1'b0;
            ctl.gpd  <= 1'b0;
            ctl.pdis <= 1'b0;
            ctl.dws  <= WSW'(1);
            ctl.pws  <= WSW'(1);
        end else if (is_reg && d_we) begin
            ctl.hold <= d_wdata[15];
            ctl.gpd  <= d_wdata[13];
            ctl.pdis <= d_wdata[12];
            ctl.dws  <= d_wdata[5 +: WSW];
            ctl.pws  <= d_wdata[0 +: WSW];
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[15]        = ctl.hold;
        rdata[14]        = busy;
        rdata[13]        = ctl.gpd;
        rdata[12]        = ctl.pdis;
        rdata[5 +: WSW]  = ctl.dws;
        rdata[0 +: WSW]  = ctl.pws;
    end
endmodule

// File: rtl/ebp_prog_gate.sv
module ebp_prog_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pdis,
    output logic pdis_q,
    output logic prog_ok
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pdis_q <= 1'b0;
        else        pdis_q <= pdis;
    end

    // Path reopens only after the bit has read 0 for a full cycle.
    assign prog_ok = !pdis && !pdis_q;
endmodule

// File: rtl/ebp_port_fsm.sv
module ebp_port_fsm
    import ebp_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_go,
    input  logic [AW-1:0] d_addr,
    input  logic          p_req,
    input  logic          p_ok,
    input  logic [AW-1:0] p_addr,
    input  bus_ctl_t      ctl,
    output logic [AW-1:0] ext_addr,
    output logic          ext_strobe,
    output logic          ext_prog,
    output logic          stall
);
    port_state_e    state, state_n;
    logic [WSW-1:0] cnt;
    logic [AW-1:0]  addr_q;
    logic           prog_q;
    logic           accept;

    assign accept = d_go || (p_req && p_ok);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (accept) state_n = ST_XFER;
            ST_XFER: state_n = (cnt == '0) ? ST_IDLE : ST_WAIT;
            ST_WAIT: state_n = (cnt == WSW'(1)) ? ST_IDLE : ST_WAIT;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            prog_q <= 1'b0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && accept) begin
                addr_q <= d_go ? d_addr : p_addr;
                prog_q <= !d_go;
                cnt    <= d_go ? ctl.dws : ctl.pws;
            end else if (state == ST_WAIT) begin
                cnt <= cnt - WSW'(1);
            end
        end
    end

    always_comb begin
        ext_addr   = addr_q;
        ext_strobe = (state != ST_IDLE);
        stall      = (state == ST_WAIT);
        ext_prog   = prog_q && (state != ST_IDLE);
    end
endmodule

// File: rtl/ext_bus_port.sv
module ext_bus_port
    import ebp_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] REG_ADDR = 16'hFFDE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_req,
    input  logic          d_we,
    input  logic [AW-1:0] d_addr,
    input  logic [15:0]   d_wdata,
    input  logic          p_req,
    input  logic [AW-1:0] p_addr,
    output logic [15:0]   reg_rdata,
    output logic [AW-1:0] ext_addr,
    output logic          ext_strobe,
    output logic          ext_prog,
    output logic          stall
);
    bus_ctl_t ctl;
    logic     is_reg;
    logic     pdis_q;
    logic     prog_ok;

    ebp_ctrl_reg #(.AW(AW), .REG_ADDR(REG_ADDR)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_req  (d_req),
        .d_we   (d_we),
        .d_addr (d_addr),
        .d_wdata(d_wdata),
        .busy   (ext_strobe),
        .ctl    (ctl),
        .is_reg (is_reg),
        .rdata  (reg_rdata)
    );

    ebp_prog_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .pdis   (ctl.pdis),
        .pdis_q (pdis_q),
        .prog_ok(prog_ok)
    );

    ebp_port_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_go      (d_req && !is_reg),
        .d_addr    (d_addr),
        .p_req     (p_req),
        .p_ok      (prog_ok),
        .p_addr    (p_addr),
        .ctl       (ctl),
        .ext_addr  (ext_addr),
        .ext_strobe(ext_strobe),
        .ext_prog  (ext_prog),
        .stall     (stall)
    );
endmodule

// File: rtl/ebp_checker.sv
module ebp_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [15:0]   reg_rdata,
    input logic [AW-1:0] ext_addr,
    input logic          ext_strobe,
    input logic          ext_prog,
    input logic          stall,
    input logic          pdis,
    input logic          pdis_q
);
    logic        strobe_q;
    logic [15:0] rd_q;
    logic [4:0]  exp_n;
    logic [5:0]  n_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            rd_q     <= '0;
            exp_n    <= '0;
            n_cnt    <= '0;
        end else begin
            strobe_q <= ext_strobe;
            rd_q     <= reg_rdata;
            if (ext_strobe && !strobe_q) begin
                exp_n <= ext_prog ? rd_q[4:0] : rd_q[9:5];
                n_cnt <= '0;
            end else if (stall) begin
                n_cnt <= n_cnt + 6'd1;
            end
        end
    end

    p_reset_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_rdata == 16'h0021 && !ext_strobe && !stall));

    p_stall_in_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ext_strobe);

    p_stall_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && !ext_strobe) |-> ({1'b0, exp_n} == n_cnt));

    p_prog_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ext_strobe) && ext_prog) |-> $past(!pdis));

    p_prog_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ext_strobe) && ext_prog) |-> $past(!pdis_q));

    p_pins_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ext_strobe) |-> $stable(ext_addr));
endmodule

bind ext_bus_port ebp_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .ext_addr  (ext_addr),
    .ext_strobe(ext_strobe),
    .ext_prog  (ext_prog),
    .stall     (stall),
    .pdis      (ctl.pdis),
    .pdis_q    (pdis_q)
);

// File: tb/tb_ext_bus_port.sv
module tb_ext_bus_port;
    logic        clk, rst_n;
    logic        d_req, d_we, p_req;
    logic [15:0] d_addr, d_wdata, p_addr;
    logic [15:0] reg_rdata, ext_addr;
    logic        ext_strobe, ext_prog, stall;

    int unsigned total = 0, failed = 0, cyc = 0, ok_from = 0;
    logic        sh_hold, sh_gpd, sh_dis;
    logic [4:0]  sh_dws, sh_pws;
    logic [15:0] last_addr;

    ext_bus_port dut (
        .clk(clk), .rst_n(rst_n), .d_req(d_req), .d_we(d_we), .d_addr(d_addr),
        .d_wdata(d_wdata), .p_req(p_req), .p_addr(p_addr), .reg_rdata(reg_rdata),
        .ext_addr(ext_addr), .ext_strobe(ext_strobe), .ext_prog(ext_prog), .stall(stall)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] exp_rd(input logic busy);
        return {sh_hold, busy, sh_gpd, sh_dis, 2'b00, sh_dws, sh_pws};
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", rq, act, exp, cyc);
        end
    endtask

    task automatic reg_write(input logic [15:0] v);
        d_req = 1'b1; d_we = 1'b1; d_addr = 16'hFFDE; d_wdata = v;
        @(negedge clk);
        d_req = 1'b0; d_we = 1'b0;
        if (sh_dis && !v[12]) ok_from = cyc + 1;
        sh_hold = v[15]; sh_gpd = v[13]; sh_dis = v[12];
        sh_dws = v[9:5]; sh_pws = v[4:0];
        check("R6", {31'd0, ext_strobe}, 0);
        check("R2", {16'd0, reg_rdata}, {16'd0, exp_rd(1'b0)});
    endtask

    task automatic access(input logic dq, input logic pq, input logic [15:0] da,
                          input logic [15:0] pa);
        logic go_d, go_p;
        logic [4:0] n;
        logic [15:0] ea;
        go_d = dq;
        go_p = !dq && pq && !sh_dis && (cyc >= ok_from);
        if (!dq && pq && !sh_dis && cyc < ok_from)
            $display("NOTE R8 protocol violation: program fetch one cycle after re-enable");
        n  = go_d ? sh_dws : sh_pws;
        ea = go_d ? da : pa;
        d_req = dq; d_we = 1'b0; d_addr = da; p_req = pq; p_addr = pa;
        @(negedge clk);
        d_req = 1'b0; p_req = 1'b0;
        if (go_d || go_p) begin
            check("R4", {31'd0, ext_strobe}, 1);
            check("R4", {16'd0, ext_addr}, {16'd0, ea});
            check("R5", {31'd0, ext_prog}, {31'd0, go_p});
            check("R4", {31'd0, stall}, 0);
            check("R3", {31'd0, reg_rdata[14]}, 1);
            last_addr = ea;
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                check("R4", {30'd0, stall, ext_strobe}, 32'd3);
                check("R9", {16'd0, ext_addr}, {16'd0, ea});
            end
            @(negedge clk);
            check("R4", {30'd0, stall, ext_strobe}, 0);
            check("R3", {16'd0, reg_rdata}, {16'd0, exp_rd(1'b0)});
        end else begin
            check("R7", {31'd0, ext_strobe}, 0);
            check("R7", {16'd0, ext_addr}, {16'd0, last_addr});
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [15:0] w, a, b;
        void'($urandom(32'd4242));
        rst_n = 1'b0; d_req = 1'b0; d_we = 1'b0; p_req = 1'b0;
        d_addr = '0; d_wdata = '0; p_addr = '0;
        sh_hold = 0; sh_gpd = 0; sh_dis = 0; sh_dws = 5'd1; sh_pws = 5'd1;
        last_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {16'd0, reg_rdata}, 32'h0021);
        check("R1", {30'd0, stall, ext_strobe}, 0);

        // default wait of 1 on both paths
        access(1'b0, 1'b1, 16'h0000, 16'h1234);
        access(1'b1, 1'b0, 16'h8001, 16'h0000);

        // R3: status and reserved bits ignore writes
        reg_write(16'h4C00 | 16'hA000 | (16'd4 << 5) | 16'd2);
        check("R3", {27'd0, reg_rdata[14:10]}, {27'd0, 5'b01000});
        reg_write(16'h0000);

        // zero wait: single strobe cycle
        access(1'b0, 1'b1, 16'h0000, 16'h00F0);
        // maximum wait
        reg_write((16'd31 << 5) | 16'd31);
        access(1'b1, 1'b0, 16'h2222, 16'h0000);
        access(1'b0, 1'b1, 16'h0000, 16'h3333);

        // R5: data wins over program in same cycle
        reg_write((16'd2 << 5) | 16'd5);
        access(1'b1, 1'b1, 16'h4444, 16'h5555);

        // R5: request during an access is dropped
        reg_write((16'd2 << 5) | 16'd3);
        d_req = 1'b0; p_req = 1'b1; p_addr = 16'h0A0A;
        @(negedge clk);
        p_req = 1'b0;
        check("R4", {31'd0, ext_strobe}, 1);
        @(negedge clk);
        d_req = 1'b1; d_addr = 16'h0B0B;
        @(negedge clk);
        d_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R5", {31'd0, ext_strobe}, 0);
        @(negedge clk);
        check("R5", {31'd0, ext_strobe}, 0);
        check("R5", {16'd0, ext_addr}, 32'h0A0A);
        last_addr = 16'h0A0A;

        // R7: disable program path; data still works, pins hold
        reg_write(16'h1000 | (16'd1 << 5) | 16'd1);
        access(1'b0, 1'b1, 16'h0000, 16'h7777);
        access(1'b1, 1'b0, 16'h6666, 16'h0000);
        access(1'b0, 1'b1, 16'h0000, 16'h9999);

        // R8: clear, fetch at once is blocked, one cycle later driven
        reg_write((16'd1 << 5) | 16'd1);
        access(1'b0, 1'b1, 16'h0000, 16'hABCD);
        access(1'b0, 1'b1, 16'h0000, 16'hBCDE);

        // constrained random mix
        for (int k = 0; k < 60; k++) begin
            if ($urandom % 8 < 2) begin
                w = 16'($urandom);
                w[9:5] = ($urandom % 10 == 0) ? 5'd31 : 5'($urandom % 7);
                w[4:0] = ($urandom % 10 == 0) ? 5'd31 : 5'($urandom % 7);
                w[12]  = ($urandom % 3 == 0);
                reg_write(w);
            end else begin
                a = 16'($urandom);
                if (a == 16'hFFDE) a = 16'hFFDF;
                b = 16'($urandom);
                case ($urandom % 3)
                    0: access(1'b1, 1'b0, a, b);
                    1: access(1'b0, 1'b1, a, b);
                    default: access(1'b1, 1'b1, a, b);
                endcase
            end
        end

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule